// File: doc/BRIEF.md
# Dual external interrupt sense unit

This unit watches two dedicated interrupt pins and turns their activity into request lines for an interrupt controller. Each pin has its own 2-bit sense selection: a held low level, any edge, a falling edge or a rising edge. Each pin also has its own enable and its own flag-clear strobe.

Edge modes work on the I/O clock. The pin passes through a synchronizer, two successive synchronized samples are compared, and a detected edge sets a sticky flag. That flag stays set until software clears it. Level mode holds no state: its request simply follows the synchronized pin, so it drops as soon as the pin returns high.

A separate wake line is formed without any clock. It tells the power controller to restart a halted device when an enabled level-mode pin is low. If that pin rises again before the clock is back, the device still wakes, but no request appears. The unit sees only the pin level, not the pin's direction. An enabled pin that the chip itself drives therefore raises requests in the same way as one driven from outside.

Top module: `ext_irq_sense`

## Requirements
- R1: Sense code 2'b10 (bits [2i+1:2i] of `mode_i` for input i) selects falling-edge detection. A high-to-low pin change sets `req_o[i]` exactly SYNC_STAGES+1 rising clock edges after the pin change is first sampled, and not earlier.
- R2: Sense code 2'b00 selects low-level sensing. `req_o[i]` equals `en_i[i]` AND NOT (the pin delayed by SYNC_STAGES clock edges), it latches nothing, and it stays low while the input is disabled.
- R3: While `clk_run_i` is low, no edge is recognized and no edge flag is set, including when the pin changes during the halt and is steady again when the clock resumes.
- R4: `wake_o` is high exactly when some input is enabled, has sense code 2'b00, and has its pin low. It is purely combinational and needs no clock edge. Inputs in edge modes never drive it.
- R5: A low pulse on a level-mode pin that ends while `clk_run_i` is low raises `wake_o` but never raises `req_o`.
- R6: In edge modes `req_o[i]` shows a sticky flag. The flag stays set until a clock edge that samples `clr_i[i]` high. If an edge is detected in the same cycle as the clear, the set wins.
- R7: Sense code 2'b11 sets the flag on a rising pin change. Sense code 2'b01 sets it on a change in either direction.
- R8: In the first cycle after `mode_i` for an input changes, edge detection on that input is suppressed. A transition seen only in that cycle is not recorded.
- R9: An edge that occurs while `en_i[i]` is low sets no flag. Enabling the input afterwards does not raise `req_o[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_io | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clk_run_i | input | 1 | High while the I/O clock is running; low gates all edge sampling |
| pin_i | input | N_IN | Raw pin levels |
| mode_i | input | 2*N_IN | Sense codes, 2 bits per input |
| en_i | input | N_IN | Per-input enable |
| clr_i | input | N_IN | Per-input edge-flag clear strobe |
| req_o | output | N_IN | Per-input interrupt request |
| wake_o | output | 1 | Asynchronous wake request |

## Verification
The bench builds the unit with N_IN=2 and SYNC_STAGES=3. Using three stages instead of the default two makes the latency checks tell the level path (three edges) apart from the edge path (four edges). It also leaves a wider window in which a mode change or a clear can be placed on the exact detection cycle. Having two inputs lets one input sit in an edge mode with its pin low while the other drives the wake line, which shows that edge-mode inputs have no effect on wake.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/ext_irq_sync.sv
// Pin synchronizer with a clock enable; holds while the I/O clock is reported halted.
// STAGES must be at least 2.
module ext_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = stg_q;
    if (ce) stg_d = {stg_q[STAGES-2:0], d};
  end

  // idle-high reset: a low-active level input must not request out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '1;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/ext_irq_chan.sv
// One input: edge compare, sticky flag, request select.
module ext_irq_chan
  import ext_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clk_run,
  input  logic   lvl_s,
  input  sense_e mode,
  input  logic   en,
  input  logic   clr,
  output logic   req
);
  logic   prev_q, prev_d;
  sense_e mode_q;
  logic   flag_q, flag_d;
  logic   hit;

  always_comb begin
    hit = 1'b0;
    // the mode must be stable for one cycle before any edge counts
    if (clk_run && en && (mode == mode_q)) begin
      case (mode)
        SENSE_ANY:  hit = prev_q ^ lvl_s;
        SENSE_FALL: hit = prev_q & ~lvl_s;
        SENSE_RISE: hit = ~prev_q & lvl_s;
        default:    hit = 1'b0;
      endcase
    end
  end

  always_comb begin
    prev_d = clk_run ? lvl_s : prev_q;
    if (hit)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
    else          flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      mode_q <= SENSE_LOW;
      flag_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      mode_q <= mode;
      flag_q <= flag_d;
    end
  end

  assign req = (mode == SENSE_LOW) ? (en & ~lvl_s) : flag_q;
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int N_IN        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_io,
  input  logic                rst_n,
  input  logic                clk_run_i,
  input  logic [N_IN-1:0]     pin_i,
  input  logic [2*N_IN-1:0]   mode_i,
  input  logic [N_IN-1:0]     en_i,
  input  logic [N_IN-1:0]     clr_i,
  output logic [N_IN-1:0]     req_o,
  output logic                wake_o
);
  localparam int MODE_W = 2;

  logic [N_IN-1:0] lvl_s;

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk_io),
      .rst_n (rst_n),
      .ce    (clk_run_i),
      .d     (pin_i[i]),
      .q     (lvl_s[i])
    );

    ext_irq_chan u_chan (
      .clk     (clk_io),
      .rst_n   (rst_n),
      .clk_run (clk_run_i),
      .lvl_s   (lvl_s[i]),
      .mode    (sense_e'(mode_i[MODE_W*i +: MODE_W])),
      .en      (en_i[i]),
      .clr     (clr_i[i]),
      .req     (req_o[i])
    );
  end

  // clockless wake path straight from the raw pins
  always_comb begin
    wake_o = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (en_i[i] && (mode_i[MODE_W*i +: MODE_W] == SENSE_LOW) && !pin_i[i])
        wake_o = 1'b1;
    end
  end
endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk #(
  parameter int N_IN = 2
) (
  input logic              clk_io,
  input logic              rst_n,
  input logic              clk_run_i,
  input logic [N_IN-1:0]   pin_i,
  input logic [2*N_IN-1:0] mode_i,
  input logic [N_IN-1:0]   en_i,
  input logic [N_IN-1:0]   clr_i,
  input logic [N_IN-1:0]   req_o,
  input logic              wake_o
);
  logic [N_IN-1:0] lvl_low_en;
  always_comb begin
    for (int i = 0; i < N_IN; i++)
      lvl_low_en[i] = en_i[i] & (mode_i[2*i +: 2] == 2'b00) & ~pin_i[i];
  end

  AST_WAKE_NEEDS_LEVEL: assert property (@(posedge clk_io) disable iff (!rst_n)
    wake_o |-> (|lvl_low_en)); // R4
  AST_WAKE_ON_LEVEL: assert property (@(posedge clk_io) disable iff (!rst_n)
    (|lvl_low_en) |-> wake_o); // R4

  for (genvar i = 0; i < N_IN; i++) begin : g_chk
    logic [1:0] m;
    assign m = mode_i[2*i +: 2];

    AST_LEVEL_GATED_BY_EN: assert property (@(posedge clk_io) disable iff (!rst_n)
      (m == 2'b00 && !en_i[i]) |-> !req_o[i]); // R2
    AST_NO_EDGE_WHEN_HALTED: assert property (@(posedge clk_io) disable iff (!rst_n)
      (!clk_run_i && m != 2'b00 && !req_o[i]) |=> (!req_o[i] || m != $past(m))); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk_io) disable iff (!rst_n)
      (req_o[i] && m != 2'b00 && !clr_i[i]) |=> (req_o[i] || m != $past(m))); // R6
    AST_CLR_WHEN_HALTED: assert property (@(posedge clk_io) disable iff (!rst_n)
      (clr_i[i] && !clk_run_i && m != 2'b00) |=> (!req_o[i] || m != $past(m))); // R6
  end
endmodule

bind ext_irq_sense ext_irq_sense_chk #(.N_IN(N_IN)) u_chk (
  .clk_io    (clk_io),
  .rst_n     (rst_n),
  .clk_run_i (clk_run_i),
  .pin_i     (pin_i),
  .mode_i    (mode_i),
  .en_i      (en_i),
  .clr_i     (clr_i),
  .req_o     (req_o),
  .wake_o    (wake_o)
);

// File: tb/ext_irq_sense_tb.sv
module ext_irq_sense_tb;
  localparam int N = 2;
  localparam int S = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_run = 1'b1;
  logic [N-1:0]   pin  = '1;
  logic [N-1:0]   en   = '0;
  logic [N-1:0]   clr  = '0;
  logic [2*N-1:0] mode = '0;
  logic [N-1:0]   req;
  logic           wake;

  always #5 clk = ~clk;

  ext_irq_sense #(.N_IN(N), .SYNC_STAGES(S)) u_dut (
    .clk_io(clk), .rst_n(rst_n), .clk_run_i(clk_run), .pin_i(pin),
    .mode_i(mode), .en_i(en), .clr_i(clr), .req_o(req), .wake_o(wake)
  );

  int vec = 0;
  int mis = 0;
  bit done = 1'b0;

  // behavioural reference: per input a delay queue of sampled pins, last seen level, flag
  logic m_hist [N][$];
  logic m_prev [N];
  logic m_flag [N];
  logic [1:0] m_mq [N];

  function automatic logic exp_req(int i);
    if (mode[2*i +: 2] == 2'b00) return en[i] & ~m_hist[i][S-1];
    return m_flag[i];
  endfunction

  function automatic logic exp_wake();
    for (int i = 0; i < N; i++)
      if (en[i] && mode[2*i +: 2] == 2'b00 && !pin[i]) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n) begin
        m_hist[i] = {};
        for (int s = 0; s < S; s++) m_hist[i].push_back(1'b1);
        m_prev[i] = 1'b1; m_flag[i] = 1'b0; m_mq[i] = 2'b00;
      end else begin
        logic cur, det;
        logic [1:0] m;
        m = mode[2*i +: 2];
        cur = m_hist[i][S-1];
        det = 1'b0;
        if (clk_run && en[i] && m != 2'b00 && m == m_mq[i]) begin
          if (m == 2'b01) det = cur != m_prev[i];
          if (m == 2'b10) det = m_prev[i] && !cur;
          if (m == 2'b11) det = !m_prev[i] && cur;
        end
        if (det) m_flag[i] = 1'b1;
        else if (clr[i]) m_flag[i] = 1'b0;
        if (clk_run) begin
          m_prev[i] = cur;
          void'(m_hist[i].pop_back());
          m_hist[i].push_front(pin[i]);
        end
        m_mq[i] = m;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      #1;
      for (int i = 0; i < N; i++) begin
        vec++;
        if (req[i] !== exp_req(i)) begin
          mis++;
          $display("FAIL %s model: req[%0d] actual %b expected %b at %0t",
                   (mode[2*i +: 2] == 2'b00) ? "R2" : "R6", i, req[i], exp_req(i), $time);
        end
      end
      vec++;
      if (wake !== exp_wake()) begin
        mis++;
        $display("FAIL R4 model: wake actual %b expected %b at %0t", wake, exp_wake(), $time);
      end
    end
  end

  task automatic check(input logic act, input logic exp, input string what);
    vec++;
    if (act !== exp) begin
      mis++;
      $display("FAIL %s: actual %b expected %b at %0t", what, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_clr(input int i);
    clr[i] = 1'b1; cyc(1); clr[i] = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    mis++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    check(req[0], 1'b0, "R2 reset req0");
    check(wake, 1'b0, "R4 reset wake");
    rst_n = 1'b1;

    // R1 falling edge latency
    mode[1:0] = 2'b10; en[0] = 1'b1; cyc(3);
    pin[0] = 1'b0; cyc(S);
    check(req[0], 1'b0, "R1 falling not yet");
    cyc(1);
    check(req[0], 1'b1, "R1 falling set");

    // R6 sticky, clear, set beats clear
    pin[0] = 1'b1; cyc(S + 3);
    check(req[0], 1'b1, "R6 sticky");
    pulse_clr(0);
    check(req[0], 1'b0, "R6 cleared");
    pin[0] = 1'b0; cyc(S);
    pulse_clr(0);
    check(req[0], 1'b1, "R6 set wins over clear");
    pulse_clr(0);
    check(req[0], 1'b0, "R6 cleared again");

    // R7 rising and any edge
    mode[1:0] = 2'b11; cyc(2);
    pin[0] = 1'b1; cyc(S + 1);
    check(req[0], 1'b1, "R7 rising");
    pulse_clr(0);
    mode[1:0] = 2'b01; cyc(2);
    pin[0] = 1'b0; cyc(S + 1);
    check(req[0], 1'b1, "R7 any edge fall");
    pulse_clr(0);
    pin[0] = 1'b1; cyc(S + 1);
    check(req[0], 1'b1, "R7 any edge rise");
    pulse_clr(0);
    check(req[0], 1'b0, "R7 cleared");

    // R8 mode change on the detection cycle
    mode[1:0] = 2'b10; cyc(2);
    pin[0] = 1'b0; cyc(S);
    mode[1:0] = 2'b01; cyc(3);
    check(req[0], 1'b0, "R8 edge suppressed by mode change");

    // R9 disabled input
    mode[1:0] = 2'b10; pin[0] = 1'b1; cyc(S + 2); pulse_clr(0);
    en[0] = 1'b0; pin[0] = 1'b0; cyc(S + 2);
    check(req[0], 1'b0, "R9 disabled edge");
    en[0] = 1'b1; cyc(1);
    check(req[0], 1'b0, "R9 enable after edge");

    // R3 halted clock
    clk_run = 1'b0; pin[0] = 1'b1; cyc(S + 2);
    pin[0] = 1'b0; cyc(S + 2);
    check(req[0], 1'b0, "R3 halted toggles");
    pin[0] = 1'b1; cyc(1);
    clk_run = 1'b1; cyc(S + 2);
    check(req[0], 1'b0, "R3 resume");

    // R4 edge-mode low pin gives no wake
    pin[0] = 1'b0; #1;
    check(wake, 1'b0, "R4 edge mode no wake");

    // R2 level on input 1
    mode[3:2] = 2'b00; en[1] = 1'b1; cyc(2);
    check(req[1], 1'b0, "R2 level idle");
    pin[1] = 1'b0; #1;
    check(wake, 1'b1, "R4 wake on low");
    cyc(S - 1);
    check(req[1], 1'b0, "R2 level latency");
    cyc(1);
    check(req[1], 1'b1, "R2 level active");
    pin[1] = 1'b1; #1;
    check(wake, 1'b0, "R4 wake drops");
    cyc(S);
    check(req[1], 1'b0, "R2 non-latching");
    en[1] = 1'b0; pin[1] = 1'b0; #1;
    check(wake, 1'b0, "R4 disabled no wake");
    cyc(S + 1);
    check(req[1], 1'b0, "R2 disabled level");

    // R5 short pulse during halt
    pin[1] = 1'b1; en[1] = 1'b1; cyc(S + 1);
    clk_run = 1'b0; pin[1] = 1'b0; #1;
    check(wake, 1'b1, "R5 wake without clock");
    cyc(2);
    check(req[1], 1'b0, "R5 no request while halted");
    pin[1] = 1'b1; #1;
    check(wake, 1'b0, "R5 wake drops");
    clk_run = 1'b1; cyc(S + 1);
    check(req[1], 1'b0, "R5 no request after resume");

    cyc(2);
    finish_run();
  end
endmodule